// File: doc/BRIEF.md
# Dual-Plane Erase Suspend Controller

This block sits beside the erase timing engine of a flash array split into planes. It accepts erase-start, suspend and resume commands. It keeps one record of the erase in flight: the sector it targets, or a flag for a whole-chip erase. It tells the engine when to start, pause and continue. The erase timing itself stays inside the engine.

For every read or program request, the block decides in the same cycle whether the access may proceed. For a granted read, it also decides whether the read returns array data or erase status. An erase blocks only the plane that holds it, so the other plane stays open while the erase runs. A suspended erase opens every sector except the one being erased. A suspended chip erase exposes array data only from locked sectors.

The plane is the top `PLANE_BITS` address bits (two by default). The sector id is the top `PLANE_BITS+SECTOR_BITS` bits. The pause settles `SUSP_LAT` cycles after the suspend command is accepted. Set this count so that it covers the 15 µs pause limit at the system clock.

Top module: `erase_suspend_ctl`

## Requirements
- R1: After reset the block is idle: `suspended`, `suspChip`, `suspPlane` and the three engine pulses are 0, and a valid request is granted with `reqStatus` 0.
- R2: A command with `cmdOp` 0 (sector erase, target sector = top address bits of `cmdAddr`) or 1 (chip erase) starts an erase only when idle, pulsing `eraseGo` for one cycle after the edge that accepted it; an erase command while an erase is running, pausing or suspended is ignored.
- R3: A command with `cmdOp` 2 (suspend, address ignored) while an erase runs pulses `pauseCmd` one cycle after acceptance; `suspended` rises exactly `SUSP_LAT` clock edges after the accepting edge, and while suspended `suspPlane` gives the plane of a sector erase (0 for chip erase) and `suspChip` is 1 for a chip erase.
- R4: A suspend command when no erase runs (idle, already pausing or suspended) is ignored.
- R5: A command with `cmdOp` 3 (resume) is accepted only when suspended and, for a sector erase, only when the top two bits of `cmdAddr` equal the suspended plane (any plane for a chip erase); it pulses `resumeCmd` and clears `suspended`. Any other resume is ignored.
- R6: `eraseDone` while running or pausing returns the block to idle; if it coincides with a suspend command, completion wins and no pause is issued.
- R7: While a sector erase runs or pauses, requests to the other plane are granted with array data and requests to other sectors of the same plane are refused.
- R8: A read of the sector under erase (running, pausing or suspended) is granted with `reqStatus` 1; a program to it is refused.
- R9: While a sector erase is suspended, every other sector in any plane is granted with array data for reads and programs.
- R10: While a chip erase runs or pauses, every read is granted with `reqStatus` 1 and every program is refused.
- R11: While a chip erase is suspended, programs are refused; reads of sectors whose `lockMap` bit is 1 return array data, and reads of unlocked sectors return status.
- R12: With `reqValid` low, `reqGrant` and `reqStatus` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | 0 sector erase, 1 chip erase, 2 suspend, 3 resume |
| cmdAddr | input | ADDR_W | Command address (erase target, resume plane) |
| eraseDone | input | 1 | Engine reports erase completion |
| lockMap | input | 2**(PLANE_BITS+SECTOR_BITS) | One bit per sector, 1 = locked |
| reqValid | input | 1 | Access request present |
| reqAddr | input | ADDR_W | Request address |
| reqProgram | input | 1 | 1 = program, 0 = read |
| reqGrant | output | 1 | Request may proceed |
| reqStatus | output | 1 | Granted read returns erase status |
| suspended | output | 1 | An erase is held in suspension |
| suspPlane | output | PLANE_BITS | Plane of the suspended sector erase |
| suspChip | output | 1 | The suspended erase is a chip erase |
| eraseGo | output | 1 | One-cycle start pulse to the engine |
| pauseCmd | output | 1 | One-cycle pause pulse to the engine |
| resumeCmd | output | 1 | One-cycle continue pulse to the engine |

## Verification
Two events can land on the same edge: completion of an erase and a suspend command. The bench presents `eraseDone` together with a suspend while the erase runs. It also raises `eraseDone` in the middle of the pause window. In both cases it expects the block to return to idle with no `pauseCmd` pulse and no later rise of `suspended`. The same comparison runs on every clock, so a late or spurious pulse in the following cycles counts as a mismatch.

// File: rtl/esusp_pkg.sv
package esusp_pkg;

  typedef enum logic [1:0] {
    OP_ERASE_SECTOR = 2'd0,
    OP_ERASE_CHIP   = 2'd1,
    OP_SUSPEND      = 2'd2,
    OP_RESUME       = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_PENDING = 2'd2,
    ST_HELD    = 2'd3
  } eraseSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTarget;  // capture erase target this edge
    logic loadChip;    // captured erase is a chip erase
    logic busy;        // erase running or pausing
    logic held;        // erase suspended
  } ctlStrobe_t;

endpackage

// File: rtl/esusp_ctrl.sv
module esusp_ctrl
  import esusp_pkg::*;
#(
  parameter int SUSP_LAT = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       eraseDone,
  input  logic       resumeMatch,
  output ctlStrobe_t strobe,
  output logic       eraseGo,
  output logic       pauseCmd,
  output logic       resumeCmd
);

  localparam int CNT_W = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUSP_LAT - 1);

  eraseSt_e         stQ, stNext;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic             goNext, pauseNext, resNext, loadT, loadC;
  cmdOp_e           op;

  always_comb begin
    op        = cmdOp_e'(cmdOp);
    stNext    = stQ;
    cntNext   = cntQ;
    goNext    = 1'b0;
    pauseNext = 1'b0;
    resNext   = 1'b0;
    loadT     = 1'b0;
    loadC     = 1'b0;
    case (stQ)
      ST_IDLE: begin
        if (cmdValid && (op == OP_ERASE_SECTOR || op == OP_ERASE_CHIP)) begin
          stNext = ST_RUN;
          goNext = 1'b1;
          loadT  = 1'b1;
          loadC  = (op == OP_ERASE_CHIP);
        end
      end
      ST_RUN: begin
        if (eraseDone) begin
          stNext = ST_IDLE;               // completion beats a suspend
        end else if (cmdValid && op == OP_SUSPEND) begin
          stNext    = ST_PENDING;
          cntNext   = '0;
          pauseNext = 1'b1;
        end
      end
      ST_PENDING: begin
        if (eraseDone) begin
          stNext = ST_IDLE;
        end else if (cntQ == CNT_LAST) begin
          stNext = ST_HELD;
        end else begin
          cntNext = cntQ + CNT_W'(1);
        end
      end
      ST_HELD: begin
        if (cmdValid && op == OP_RESUME && resumeMatch) begin
          stNext  = ST_RUN;
          resNext = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ       <= ST_IDLE;
      cntQ      <= '0;
      eraseGo   <= 1'b0;
      pauseCmd  <= 1'b0;
      resumeCmd <= 1'b0;
    end else begin
      stQ       <= stNext;
      cntQ      <= cntNext;
      eraseGo   <= goNext;
      pauseCmd  <= pauseNext;
      resumeCmd <= resNext;
    end
  end

  always_comb begin
    strobe.loadTarget = loadT;
    strobe.loadChip   = loadC;
    strobe.busy       = (stQ == ST_RUN) || (stQ == ST_PENDING);
    strobe.held       = (stQ == ST_HELD);
  end

  // R2: a start pulse only follows an idle cycle and leaves the block busy
  a_r2_go_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |-> (strobe.busy && $past(stQ == ST_IDLE)));

  // R3: a pause pulse always coincides with the pause window
  a_r3_pause_in_window: assert property (@(posedge clk) disable iff (!rstN)
    pauseCmd |-> (stQ == ST_PENDING));

  // R3: the pause window counter stays inside its bound
  a_r3_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_PENDING) |-> (cntQ <= CNT_LAST));

  // R3: suspension is only entered from the pause window
  a_r3_held_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.held) |-> $past(stQ == ST_PENDING));

  // R5: a continue pulse follows a held cycle and the erase runs again
  a_r5_resume_from_held: assert property (@(posedge clk) disable iff (!rstN)
    resumeCmd |-> ($past(stQ == ST_HELD) && stQ == ST_RUN));

endmodule

// File: rtl/esusp_dp.sv
module esusp_dp
  import esusp_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int PLANE_BITS  = 2,
  parameter int SECTOR_BITS = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobe_t                        strobe,
  input  logic [ADDR_W-1:0]                 cmdAddr,
  input  logic [2**(PLANE_BITS+SECTOR_BITS)-1:0] lockMap,
  input  logic                              reqValid,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic                              reqProgram,
  output logic                              resumeMatch,
  output logic                              reqGrant,
  output logic                              reqStatus,
  output logic [PLANE_BITS-1:0]             suspPlane,
  output logic                              suspChip
);

  localparam int SID_W = PLANE_BITS + SECTOR_BITS;
  localparam int LOW_W = ADDR_W - SID_W;

  logic [SID_W-1:0]      tgtSid, reqSid, cmdSid;
  logic                  tgtChip;
  logic [PLANE_BITS-1:0] tgtPlane, reqPlane, cmdPlane;
  logic                  inSector, samePlane, isLocked;
  logic                  unusedLow;

  assign cmdSid    = cmdAddr[ADDR_W-1 -: SID_W];
  assign reqSid    = reqAddr[ADDR_W-1 -: SID_W];
  assign cmdPlane  = cmdAddr[ADDR_W-1 -: PLANE_BITS];
  assign reqPlane  = reqAddr[ADDR_W-1 -: PLANE_BITS];
  assign tgtPlane  = tgtSid[SID_W-1 -: PLANE_BITS];
  assign unusedLow = ^{cmdAddr[LOW_W-1:0], reqAddr[LOW_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtSid  <= '0;
      tgtChip <= 1'b0;
    end else if (strobe.loadTarget) begin
      tgtSid  <= cmdSid;
      tgtChip <= strobe.loadChip;
    end
  end

  assign resumeMatch = tgtChip || (cmdPlane == tgtPlane);
  assign inSector    = (reqSid == tgtSid);
  assign samePlane   = (reqPlane == tgtPlane);
  assign isLocked    = lockMap[reqSid];

  always_comb begin
    reqGrant  = 1'b0;
    reqStatus = 1'b0;
    if (reqValid) begin
      if (strobe.busy) begin
        if (tgtChip || inSector) begin
          reqGrant  = !reqProgram;
          reqStatus = !reqProgram;
        end else begin
          reqGrant  = !samePlane;
        end
      end else if (strobe.held) begin
        if (tgtChip) begin
          reqGrant  = !reqProgram;
          reqStatus = !reqProgram && !isLocked;
        end else if (inSector) begin
          reqGrant  = !reqProgram;
          reqStatus = !reqProgram;
        end else begin
          reqGrant  = 1'b1;
        end
      end else begin
        reqGrant = 1'b1;
      end
    end
  end

  assign suspPlane = (strobe.held && !tgtChip) ? tgtPlane : '0;
  assign suspChip  = strobe.held && tgtChip;

  // R12: no grant or status without a request
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!reqGrant && !reqStatus));

  // R8: status data is only ever returned on a granted read
  a_r8_status_is_read: assert property (@(posedge clk) disable iff (!rstN)
    reqStatus |-> (reqGrant && !reqProgram));

  // R8: no program reaches the sector under erase
  a_r8_target_program_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqProgram && (strobe.busy || strobe.held) && !tgtChip && inSector)
      |-> !reqGrant);

  // R7: the other plane stays open while a sector erase runs
  a_r7_other_plane_open: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strobe.busy && !tgtChip && !samePlane) |-> (reqGrant && !reqStatus));

  // R11: a suspended chip erase hides array data of unlocked sectors
  a_r11_unlocked_hidden: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqProgram && suspChip && !isLocked) |-> reqStatus);

endmodule

// File: rtl/erase_suspend_ctl.sv
module erase_suspend_ctl
  import esusp_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int PLANE_BITS  = 2,
  parameter int SECTOR_BITS = 4,
  parameter int SUSP_LAT    = 3000
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   cmdValid,
  input  logic [1:0]                             cmdOp,
  input  logic [ADDR_W-1:0]                      cmdAddr,
  input  logic                                   eraseDone,
  input  logic [2**(PLANE_BITS+SECTOR_BITS)-1:0] lockMap,
  input  logic                                   reqValid,
  input  logic [ADDR_W-1:0]                      reqAddr,
  input  logic                                   reqProgram,
  output logic                                   reqGrant,
  output logic                                   reqStatus,
  output logic                                   suspended,
  output logic [PLANE_BITS-1:0]                  suspPlane,
  output logic                                   suspChip,
  output logic                                   eraseGo,
  output logic                                   pauseCmd,
  output logic                                   resumeCmd
);

  ctlStrobe_t strobe;
  logic       resumeMatch;

  esusp_ctrl #(.SUSP_LAT(SUSP_LAT)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .eraseDone   (eraseDone),
    .resumeMatch (resumeMatch),
    .strobe      (strobe),
    .eraseGo     (eraseGo),
    .pauseCmd    (pauseCmd),
    .resumeCmd   (resumeCmd)
  );

  esusp_dp #(
    .ADDR_W      (ADDR_W),
    .PLANE_BITS  (PLANE_BITS),
    .SECTOR_BITS (SECTOR_BITS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdAddr     (cmdAddr),
    .lockMap     (lockMap),
    .reqValid    (reqValid),
    .reqAddr     (reqAddr),
    .reqProgram  (reqProgram),
    .resumeMatch (resumeMatch),
    .reqGrant    (reqGrant),
    .reqStatus   (reqStatus),
    .suspPlane   (suspPlane),
    .suspChip    (suspChip)
  );

  assign suspended = strobe.held;

endmodule

// File: tb/erase_suspend_ctl_test.sv
`timescale 1ns/1ps
module erase_suspend_ctl_test;

  localparam int AW  = 8;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdAddr = 8'h00;
  logic       eraseDone = 1'b0;
  logic [15:0] lockMap = 16'h0008;
  logic       reqValid = 1'b0;
  logic [7:0] reqAddr = 8'h00;
  logic       reqProgram = 1'b0;
  logic       reqGrant, reqStatus, suspended, suspChip, eraseGo, pauseCmd, resumeCmd;
  logic [1:0] suspPlane;

  always #2.5 clk = ~clk;

  erase_suspend_ctl #(.ADDR_W(AW), .PLANE_BITS(2), .SECTOR_BITS(2), .SUSP_LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .eraseDone(eraseDone), .lockMap(lockMap), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqProgram(reqProgram), .reqGrant(reqGrant), .reqStatus(reqStatus),
    .suspended(suspended), .suspPlane(suspPlane), .suspChip(suspChip),
    .eraseGo(eraseGo), .pauseCmd(pauseCmd), .resumeCmd(resumeCmd));

  int    compared = 0;
  int    mismatched = 0;
  string tag = "R1";
  bit    checking = 1'b0;
  bit    finished = 1'b0;

  // reference model: 0 idle, 1 running, 2 pausing, 3 suspended
  int mMode = 0, mCnt = 0, mSid = 0;
  bit mChip = 0, eGo = 0, ePause = 0, eRes = 0;

  always @(posedge clk) begin
    bit g, p, r;
    g = 0; p = 0; r = 0;
    if (!rstN) begin
      mMode = 0; mCnt = 0; mSid = 0; mChip = 0;
    end else begin
      case (mMode)
        0: if (cmdValid && cmdOp <= 2'd1) begin
             mMode = 1; mSid = int'(cmdAddr) / 16; mChip = (cmdOp == 2'd1); g = 1;
           end
        1: if (eraseDone) mMode = 0;
           else if (cmdValid && cmdOp == 2'd2) begin mMode = 2; mCnt = 0; p = 1; end
        2: if (eraseDone) mMode = 0;
           else if (mCnt == LAT - 1) mMode = 3;
           else mCnt = mCnt + 1;
        default: if (cmdValid && cmdOp == 2'd3 &&
                     (mChip || int'(cmdAddr) / 64 == mSid / 4)) begin
                   mMode = 1; r = 1;
                 end
      endcase
    end
    eGo = g; ePause = p; eRes = r;
    checking = 1'b1;
  end

  task automatic check1(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int eg, es, sid;
    bit busy, held;
    if (checking && !finished) begin
      sid  = int'(reqAddr) / 16;
      busy = (mMode == 1 || mMode == 2);
      held = (mMode == 3);
      eg = 0; es = 0;
      if (!reqValid) begin eg = 0; es = 0; end
      else if (busy) begin
        if (mChip || sid == mSid) begin eg = !reqProgram; es = !reqProgram; end
        else if (sid / 4 == mSid / 4) eg = 0;
        else eg = 1;
      end else if (held) begin
        if (mChip) begin
          eg = !reqProgram; es = (!reqProgram && !lockMap[sid]) ? 1 : 0;
        end else if (sid == mSid) begin eg = !reqProgram; es = !reqProgram; end
        else eg = 1;
      end else eg = 1;
      check1("reqGrant", int'(reqGrant), eg);
      check1("reqStatus", int'(reqStatus), es);
      check1("suspended", int'(suspended), int'(held));
      check1("suspPlane", int'(suspPlane), (held && !mChip) ? mSid / 4 : 0);
      check1("suspChip", int'(suspChip), int'(held && mChip));
      check1("eraseGo", int'(eraseGo), int'(eGo));
      check1("pauseCmd", int'(pauseCmd), int'(ePause));
      check1("resumeCmd", int'(resumeCmd), int'(eRes));
    end
  end

  task automatic drive(string t, bit cv, logic [1:0] op, logic [7:0] ca, bit dn,
                       bit rv, logic [7:0] ra, bit rp);
    @(posedge clk);
    #1;
    tag = t; cmdValid = cv; cmdOp = op; cmdAddr = ca; eraseDone = dn;
    reqValid = rv; reqAddr = ra; reqProgram = rp;
  endtask

  task automatic rd(string t, logic [7:0] ra, bit rp);
    drive(t, 0, 2'd0, 8'h00, 0, 1, ra, rp);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #100000;
    compared++; mismatched++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) rd("R1", 8'h20, 0);
    @(posedge clk); #1 rstN = 1'b1;
    rd("R1", 8'h20, 0);
    rd("R1", 8'h90, 1);
    // R12 no request
    drive("R12", 0, 2'd0, 8'h00, 0, 0, 8'h50, 0);
    // R4 suspend and resume when idle
    drive("R4", 1, 2'd2, 8'h00, 0, 1, 8'h20, 0);
    drive("R4", 1, 2'd3, 8'h40, 0, 1, 8'h20, 1);
    rd("R4", 8'h20, 0);
    // R2 sector erase of sector 5 (plane 1)
    drive("R2", 1, 2'd0, 8'h50, 0, 1, 8'h50, 0);
    rd("R2", 8'h50, 0);
    drive("R2", 1, 2'd1, 8'h00, 0, 1, 8'hC0, 0);
    rd("R2", 8'hC0, 0);
    // R7 other plane open, same plane closed
    rd("R7", 8'hC0, 0);
    rd("R7", 8'hC4, 1);
    rd("R7", 8'h60, 0);
    rd("R7", 8'h70, 1);
    // R8 target sector
    rd("R8", 8'h55, 0);
    rd("R8", 8'h5F, 1);
    // R3 suspend, pause window
    drive("R3", 1, 2'd2, 8'h00, 0, 1, 8'h60, 0);
    rd("R3", 8'h60, 0);
    drive("R5", 1, 2'd3, 8'h40, 0, 1, 8'h60, 0);
    repeat (LAT) rd("R3", 8'h00, 0);
    // R9 suspended sector erase
    rd("R9", 8'h60, 0);
    rd("R9", 8'h70, 1);
    rd("R9", 8'h00, 1);
    rd("R8", 8'h50, 0);
    rd("R8", 8'h50, 1);
    // R2/R4 ignored while suspended
    drive("R2", 1, 2'd0, 8'h20, 0, 1, 8'h20, 0);
    rd("R2", 8'h50, 0);
    drive("R4", 1, 2'd2, 8'h00, 0, 1, 8'h60, 0);
    rd("R4", 8'h60, 0);
    // R5 wrong plane then right plane
    drive("R5", 1, 2'd3, 8'h80, 0, 1, 8'h60, 0);
    rd("R5", 8'h60, 0);
    drive("R5", 1, 2'd3, 8'h7F, 0, 1, 8'h60, 0);
    rd("R5", 8'h60, 0);
    rd("R7", 8'h10, 1);
    // R6 completion together with a suspend
    drive("R6", 1, 2'd2, 8'h00, 1, 1, 8'h60, 0);
    repeat (LAT + 2) rd("R6", 8'h60, 1);
    // R10 chip erase
    drive("R10", 1, 2'd1, 8'h90, 0, 1, 8'h30, 0);
    rd("R10", 8'h30, 0);
    rd("R10", 8'hF0, 1);
    rd("R10", 8'h90, 0);
    // R11 chip erase suspend
    drive("R11", 1, 2'd2, 8'hAA, 0, 1, 8'h30, 0);
    repeat (LAT + 1) rd("R11", 8'h30, 0);
    rd("R11", 8'h90, 0);
    rd("R11", 8'h30, 1);
    rd("R11", 8'hE0, 1);
    drive("R5", 1, 2'd3, 8'hC0, 0, 1, 8'h30, 0);
    rd("R10", 8'h30, 0);
    // R6 completion during the pause window
    drive("R6", 1, 2'd2, 8'h00, 0, 1, 8'h30, 0);
    rd("R6", 8'h30, 0);
    drive("R6", 0, 2'd0, 8'h00, 1, 1, 8'h30, 0);
    repeat (LAT + 2) rd("R6", 8'h30, 1);
    drive("R12", 0, 2'd0, 8'h00, 0, 0, 8'h00, 0);
    rd("R1", 8'h00, 0);
    summary();
  end

endmodule